// File: doc/BRIEF.md
# Phase-Selectable Output Clock Divider

This block produces one divided output clock from a fast distribution clock. Two 4-bit counts, one for the high part and one for the low part of the period, set both the division ratio and the duty cycle. A 4-bit offset shifts the waveform by whole input cycles, and a level bit picks whether a period opens high or low. Several of these channels can share one active-low restart line. Each channel then comes back at its own programmed offset, which gives coarse skew between the outputs.

Settings are written into a shadow copy over a parallel port and have no effect until they are applied. They are applied when the restart line is low, or at the next period boundary after an update pulse. A period that is already running is never cut short. Two further settings replace the divided waveform. One holds the output at its opening level. The other passes the input clock straight through, which gives divide-by-one.

Top module: `clkdiv_channel`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `div_out` is low. The active settings reset to all zeros, which means a ratio of 2, a low opening level, offset 0, no hold and no pass-through.
- R2: The period is (HI+1)+(LO+1) input cycles. HI is `cfg_ratio[3:0]` and LO is `cfg_ratio[7:4]`, so ratios from 2 to 32 are possible.
- R3: The opening level is `cfg_phase[4]`. When it is 1, each period is HI+1 cycles high followed by LO+1 cycles low. When it is 0, each period is LO+1 cycles low followed by HI+1 cycles high.
- R4: The offset is `cfg_phase[3:0]`. The level in the k-th cycle after `sync_n` returns high (k = 0 is the first) is the period pattern at position (k − offset) mod ratio.
- R5: An offset equal to or larger than the ratio wraps modulo the ratio. Offsets that are equal modulo the ratio give identical outputs, so a ratio of D has exactly D distinct alignments.
- R6: While `sync_n` is low, the shadow settings become active, the period restarts, and `div_out` (when not in pass-through) rests at the shadow opening level.
- R7: A pulse on `cfg_wr` only loads the shadow settings. The output waveform does not change until a restart or an applied update.
- R8: A pulse on `cfg_upd` makes the shadow settings take effect at the next period boundary. The new pattern starts at position 0, and the offset field is not applied again.
- R9: When `cfg_phase[5]` is active, `div_out` holds the opening level. When `cfg_phase[6]` is active, `div_out` follows `clk` (divide by one), and this takes priority over the hold setting.
- R10: A restart drops any update that is waiting. A shadow write made after the restart stays unapplied at later period boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Distribution clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load strobe for the shadow settings |
| cfg_ratio | input | 8 | LO count in [7:4], HI count in [3:0] |
| cfg_phase | input | 7 | Offset in [3:0], opening level in [4], hold in [5], pass-through in [6] |
| cfg_upd | input | 1 | Apply the shadow settings at the next period boundary |
| sync_n | input | 1 | Active-low restart and alignment |
| div_out | output | 1 | Divided clock output |

## Verification
The waveform is tried with a symmetric-odd split (HI=1, LO=2) and a lopsided split (HI=3, LO=5), each under both opening levels. This separates a swapped high and low count from an inverted start. Offsets 3 and 13 at ratio 5 must give the same trace, which shows the wrap applies and is not a saturation or truncation. Update pulses are placed mid-period and immediately before a restart, to tell boundary-timed application apart from immediate loading, and to catch a waiting update that survives a restart. The extremes of ratio 2 and ratio 32 with offset 15 cover the limits of the count.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {
    OM_DIVIDE = 2'd0,
    OM_HOLD   = 2'd1,
    OM_PASS   = 2'd2
  } out_mode_e;

  // pass-through outranks hold
  function automatic out_mode_e pick_mode(input logic pass, input logic hold);
    if (pass)      return OM_PASS;
    else if (hold) return OM_HOLD;
    else           return OM_DIVIDE;
  endfunction

  // offset modulo ratio by bounded repeated subtraction (ratio >= 2)
  function automatic int unsigned wrap_offset(input int unsigned off,
                                              input int unsigned ratio);
    int unsigned r;
    r = off;
    for (int i = 0; i < 32; i++) begin
      if (r >= ratio) r = r - ratio;
    end
    return r;
  endfunction

endpackage

// File: rtl/clkdiv_cfg_regs.sv
module clkdiv_cfg_regs #(
  parameter int CNT_W = 4,
  parameter int OFS_W = 4,
  localparam int RAT_W = 2 * CNT_W,
  localparam int PHB_W = OFS_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [RAT_W-1:0] cfg_ratio,
  input  logic [PHB_W-1:0] cfg_phase,
  input  logic             cfg_upd,
  input  logic             sync_n,
  input  logic             at_wrap,
  output logic [RAT_W-1:0] act_ratio,
  output logic [PHB_W-1:0] act_phase,
  output logic [RAT_W-1:0] sh_ratio,
  output logic [OFS_W-1:0] sh_ofs,
  output logic             sh_start
);

  logic [PHB_W-1:0] sh_phase;
  logic             pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_ratio  <= '0;
      sh_phase  <= '0;
      act_ratio <= '0;
      act_phase <= '0;
      pend      <= 1'b0;
    end else begin
      if (cfg_wr) begin
        sh_ratio <= cfg_ratio;
        sh_phase <= cfg_phase;
      end
      if (!sync_n) begin
        act_ratio <= sh_ratio;
        act_phase <= sh_phase;
        pend      <= 1'b0;
      end else if (at_wrap && (pend || cfg_upd)) begin
        act_ratio <= sh_ratio;
        act_phase <= sh_phase;
        pend      <= 1'b0;
      end else if (cfg_upd) begin
        pend <= 1'b1;
      end
    end
  end

  assign sh_ofs   = sh_phase[OFS_W-1:0];
  assign sh_start = sh_phase[OFS_W];

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sync_n && !at_wrap) |=> ($stable(act_ratio) && $stable(act_phase))); // R7

  AST_PEND_DROP: assert property (@(posedge clk) disable iff (rst)
    (!sync_n) |=> !pend); // R10

endmodule

// File: rtl/clkdiv_pos_counter.sv
module clkdiv_pos_counter #(
  parameter int CNT_W = 4,
  localparam int POS_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_n,
  input  logic [POS_W-1:0] last_pos,
  input  logic [POS_W-1:0] preset,
  output logic [POS_W-1:0] pos,
  output logic             at_wrap
);

  assign at_wrap = sync_n && (pos == last_pos);

  always_ff @(posedge clk) begin
    if (rst)           pos <= '0;
    else if (!sync_n)  pos <= preset;
    else if (at_wrap)  pos <= '0;
    else               pos <= pos + 1'b1;
  end

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos <= last_pos); // R2

  AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
    (sync_n && !at_wrap) |=> (pos == $past(pos) + 1'b1)); // R2

endmodule

// File: rtl/clkdiv_wave_gen.sv
module clkdiv_wave_gen
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 4,
  localparam int POS_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_n,
  input  logic [POS_W-1:0] pos,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic             act_start,
  input  logic             act_hold,
  input  logic             act_pass,
  input  logic             park_start,
  output logic             div_out
);

  logic      lvl;
  logic      pat;
  out_mode_e mode;

  assign mode = pick_mode(act_pass, act_hold);

  always_comb begin
    if (act_start) pat = (pos <= {1'b0, hi_cnt});
    else           pat = (pos >  {1'b0, lo_cnt});
  end

  always_ff @(posedge clk) begin
    if (rst)                  lvl <= 1'b0;
    else if (!sync_n)         lvl <= park_start;
    else if (mode == OM_HOLD) lvl <= act_start;
    else                      lvl <= pat;
  end

  assign div_out = (mode == OM_PASS) ? clk : lvl;

  AST_PARK_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!sync_n) |=> (lvl == act_start)); // R6

  AST_HOLD_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (sync_n && act_hold && !act_pass) |=> (lvl == $past(act_start))); // R9

endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int OFS_W = 4,
  localparam int RAT_W = 2 * CNT_W,
  localparam int PHB_W = OFS_W + 3,
  localparam int POS_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [RAT_W-1:0] cfg_ratio,
  input  logic [PHB_W-1:0] cfg_phase,
  input  logic             cfg_upd,
  input  logic             sync_n,
  output logic             div_out
);

  logic [RAT_W-1:0] act_ratio, sh_ratio;
  logic [PHB_W-1:0] act_phase;
  logic [OFS_W-1:0] sh_ofs;
  logic             sh_start;
  logic [POS_W-1:0] pos, last_pos, preset;
  logic             at_wrap;

  clkdiv_cfg_regs #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_ratio(cfg_ratio),
    .cfg_phase(cfg_phase), .cfg_upd(cfg_upd), .sync_n(sync_n),
    .at_wrap(at_wrap), .act_ratio(act_ratio), .act_phase(act_phase),
    .sh_ratio(sh_ratio), .sh_ofs(sh_ofs), .sh_start(sh_start)
  );

  // last position of the active period: HI + LO + 1
  assign last_pos = {1'b0, act_ratio[CNT_W-1:0]} + {1'b0, act_ratio[RAT_W-1:CNT_W]} + 1'b1;

  // restart position so that pattern position 0 appears OFS cycles after release
  always_comb begin
    int unsigned ratio, ofs_m;
    ratio = int'(sh_ratio[CNT_W-1:0]) + int'(sh_ratio[RAT_W-1:CNT_W]) + 2;
    ofs_m = wrap_offset(int'(sh_ofs), ratio);
    if (ofs_m == 0) preset = '0;
    else            preset = POS_W'(ratio - ofs_m);
  end

  clkdiv_pos_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .sync_n(sync_n), .last_pos(last_pos),
    .preset(preset), .pos(pos), .at_wrap(at_wrap)
  );

  clkdiv_wave_gen #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst(rst), .sync_n(sync_n), .pos(pos),
    .hi_cnt(act_ratio[CNT_W-1:0]), .lo_cnt(act_ratio[RAT_W-1:CNT_W]),
    .act_start(act_phase[OFS_W]), .act_hold(act_phase[OFS_W+1]),
    .act_pass(act_phase[OFS_W+2]), .park_start(sh_start), .div_out(div_out)
  );

  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> (div_out == 1'b0)); // R1

endmodule

// File: tb/clkdiv_channel_tb.sv
`timescale 1ns/1ps
module clkdiv_channel_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_ratio = '0;
  logic [6:0] cfg_phase = '0;
  logic       cfg_upd = 1'b0;
  logic       sync_n = 1'b1;
  logic       div_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;
  string req = "R1";

  // reference model state
  int m_shr = 0, m_shp = 0, m_ar = 0, m_ap = 0, m_pos = 0, m_lvl = 0, m_pend = 0;
  int trace_a[$];
  int trace_b[$];
  bit rec_a = 0, rec_b = 0;

  always #4 clk = ~clk;

  clkdiv_channel u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_ratio(cfg_ratio),
    .cfg_phase(cfg_phase), .cfg_upd(cfg_upd), .sync_n(sync_n), .div_out(div_out)
  );

  function automatic int period_of(int r);
    return (r & 15) + ((r >> 4) & 15) + 2;
  endfunction

  function automatic int shape(int ap, int ar, int p);
    int h, l;
    h = ar & 15;
    l = (ar >> 4) & 15;
    if ((ap >> 4) & 1) return (p <= h) ? 1 : 0;
    return (p > l) ? 1 : 0;
  endfunction

  task automatic check(input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: div_out=%0d expected %0d", req, cyc, got, exp);
    end
  endtask

  always @(posedge clk) begin
    int nshr, nshp, d;
    cyc++;
    nshr = cfg_wr ? int'(cfg_ratio) : m_shr;
    nshp = cfg_wr ? int'(cfg_phase) : m_shp;
    if (rst) begin
      m_shr = 0; m_shp = 0; m_ar = 0; m_ap = 0; m_pos = 0; m_lvl = 0; m_pend = 0;
      nshr = 0; nshp = 0;
    end else if (!sync_n) begin
      m_ar = m_shr; m_ap = m_shp;
      d = period_of(m_ar);
      m_pos = (d - ((m_shp & 15) % d)) % d;
      m_lvl = (m_shp >> 4) & 1;
      m_pend = 0;
    end else begin
      m_lvl = ((m_ap >> 5) & 1) ? ((m_ap >> 4) & 1) : shape(m_ap, m_ar, m_pos);
      if (m_pos == period_of(m_ar) - 1) begin
        m_pos = 0;
        if (m_pend || cfg_upd) begin
          m_ar = m_shr; m_ap = m_shp; m_pend = 0;
        end
      end else begin
        m_pos++;
        if (cfg_upd) m_pend = 1;
      end
    end
    m_shr = nshr; m_shp = nshp;
    #1;
    if (((m_ap >> 6) & 1) != 0) check(div_out, 1);
    else                        check(div_out, m_lvl);
    if (rec_a) trace_a.push_back(int'(div_out));
    if (rec_b) trace_b.push_back(int'(div_out));
  end

  // low phase of the clock: pass-through must show low, divided level unchanged
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (((m_ap >> 6) & 1) != 0) check(div_out, 0);
      else                        check(div_out, m_lvl);
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run hung, cycles=%0d expected below %0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] r, input logic [6:0] p);
    @(negedge clk);
    cfg_ratio = r; cfg_phase = p; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic restart(input int n);
    @(negedge clk);
    sync_n = 1'b0;
    run(n);
    sync_n = 1'b1;
  endtask

  task automatic pulse_upd;
    @(negedge clk);
    cfg_upd = 1'b1;
    @(negedge clk);
    cfg_upd = 1'b0;
  endtask

  initial begin
    // R1: reset state and default ratio-2 waveform after reset
    req = "R1";
    run(4);
    rst = 1'b0;
    run(10);

    // R7: shadow write alone leaves the running waveform untouched
    req = "R7";
    write_cfg(8'h21, 7'h10);
    run(12);

    // R2 R3: ratio 5 (HI=1, LO=2), opening high; then opening low
    req = "R6";
    restart(3);
    req = "R2";
    run(20);
    req = "R3";
    write_cfg(8'h21, 7'h00);
    restart(2);
    run(15);
    write_cfg(8'h53, 7'h10);
    restart(2);
    run(25);
    write_cfg(8'h53, 7'h00);
    restart(2);
    run(25);

    // R4: offset 3 at ratio 5, recorded for comparison
    req = "R4";
    write_cfg(8'h21, 7'h13);
    restart(2);
    rec_a = 1;
    run(20);
    rec_a = 0;

    // R5: offset 13 wraps to 3 at ratio 5
    req = "R5";
    write_cfg(8'h21, 7'h1D);
    restart(2);
    rec_b = 1;
    run(20);
    rec_b = 0;
    n_chk++;
    if (trace_a.size() != trace_b.size() || trace_a != trace_b) begin
      n_fail++;
      $display("FAIL R5: offset 13 trace size %0d differs from offset 3 trace size %0d or content",
               trace_b.size(), trace_a.size());
    end

    // R8: update applied only at the period boundary
    req = "R8";
    write_cfg(8'h00, 7'h10);
    run(2);
    pulse_upd;
    run(20);
    write_cfg(8'h73, 7'h00);
    pulse_upd;
    run(30);

    // R10: restart drops a waiting update
    req = "R10";
    write_cfg(8'h22, 7'h10);
    restart(2);
    write_cfg(8'hF0, 7'h00);
    @(negedge clk);
    cfg_upd = 1'b1;
    sync_n = 1'b0;
    @(negedge clk);
    cfg_upd = 1'b0;
    sync_n = 1'b1;
    write_cfg(8'h11, 7'h10);
    run(60);

    // R9: hold at opening level, then pass-through, then pass-through over hold
    req = "R9";
    write_cfg(8'h21, 7'h30);
    restart(2);
    run(15);
    write_cfg(8'h21, 7'h40);
    restart(2);
    run(10);
    write_cfg(8'h21, 7'h60);
    pulse_upd;
    run(10);
    write_cfg(8'h21, 7'h10);
    restart(2);
    run(10);

    // R2 R4: extreme ratios 32 and 2 with the largest offset
    req = "R2";
    write_cfg(8'hFF, 7'h1F);
    restart(2);
    run(80);
    req = "R4";
    write_cfg(8'h00, 7'h0F);
    restart(2);
    run(10);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule